// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 32-bit memory address from up to three terms: a base register value, an index register value scaled by 1, 2, 4 or 8, and a signed constant displacement. The base and index come from a small internal file of eight 32-bit registers. A write port on that file lets the surrounding logic, or a testbench, place values in it. Each request carries the operand selections already decoded from an instruction. These are a presence bit and a register number for the base and for the index, a 2-bit scale code, and the displacement with a size code.

Either register term may be left out. A size code of zero drops the displacement. The result is registered, so the address and a matching valid strobe appear one clock after the request. The stack pointer, register number 4, cannot serve as an index. Selecting it raises an illegal-encoding flag alongside the address, and the index term then counts as zero. The base may name any register, including number 4.

Top module: `agu_scaled_index`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ea_valid`, `ea_illegal` and `ea_addr` are 0. Reset also clears all eight registers to 0.
- R2: `ea_valid` is 1 in the cycle after a cycle with `req_valid` = 1, and 0 in the cycle after a cycle with `req_valid` = 0.
- R3: The address equals the base term plus the scaled index term plus the displacement term. The base term is the selected register when `base_en` = 1 and 0 otherwise. The index term is 0 when `idx_en` = 0.
- R4: The scale code multiplies the index register by 1, 2, 4 or 8 for codes 0, 1, 2 and 3. The bits shifted past bit 31 are lost.
- R5: The displacement size code selects the displacement term. Code 0 gives zero. Code 1 gives `disp[7:0]` sign-extended, and code 2 gives `disp[15:0]` sign-extended. Code 3 gives all 32 bits. Input bits above the chosen size have no effect.
- R6: With `idx_en` = 1 and `idx_sel` = 4, `ea_illegal` is 1 and the index term is 0. With `idx_en` = 0, `ea_illegal` is 0 whatever `idx_sel` holds. The base may be register 4 without raising the flag.
- R7: Registers are numbered 0 to 7. `rf_we` = 1 at a rising edge stores `rf_wdata` into register `rf_waddr`. A request in the same cycle as a write to a register it reads sees the new value.
- R8: The sum wraps modulo 2^32.
- R9: When `req_valid` = 0, `ea_addr` and `ea_illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 3 | Register number to write |
| rf_wdata | input | 32 | Data to write |
| req_valid | input | 1 | Request strobe for an address computation |
| base_en | input | 1 | Base register term present |
| base_sel | input | 3 | Base register number |
| idx_en | input | 1 | Index register term present |
| idx_sel | input | 3 | Index register number (4 is illegal) |
| scale_code | input | 2 | Index shift amount: 0..3 means x1, x2, x4, x8 |
| disp_size | input | 2 | 0 none, 1 one byte, 2 two bytes, 3 four bytes |
| disp | input | 32 | Displacement constant, low bytes used per size |
| ea_valid | output | 1 | Address valid, one cycle after request |
| ea_addr | output | 32 | Effective address |
| ea_illegal | output | 1 | Index register was the stack pointer |

## Verification
The hardest case to reach from the ports is a register write that collides with a request reading the same register in the same cycle. Getting there needs the write port and the request inputs driven together on one edge. It is followed by a second read of that register after the write has settled, so forwarding and storage are each confirmed. The wrap cases are also hard to hit: a large index shifted by 8, and negative short displacements that pull a small base below zero. They need register contents set up on purpose, and the vector table loads those values before it walks through its cases.

// File: rtl/agu_pkg.sv
package agu_pkg;

   localparam int SCALE_W = 2;
   localparam int DSZ_W   = 2;

   typedef enum logic [DSZ_W-1:0] {
      DSZ_NONE = 2'd0,
      DSZ_BYTE = 2'd1,
      DSZ_HALF = 2'd2,
      DSZ_WORD = 2'd3
   } disp_size_e;

   typedef enum int {
      SCALE_SHIFTER = 0,
      SCALE_MUX     = 1
   } scale_style_e;

   typedef enum int {
      SUM_RIPPLE = 0,
      SUM_CSA    = 1
   } sum_style_e;

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 32,
   parameter bit BYPASS   = 1'b1,
   localparam int SEL_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SEL_W-1:0]  raddr_a,
   input  logic [SEL_W-1:0]  raddr_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b
);

   logic [DATA_W-1:0] regs [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (we) begin
         regs[waddr] <= wdata;
      end
   end

   generate
      if (BYPASS) begin : g_fwd
         always_comb begin
            rdata_a = (we && waddr == raddr_a) ? wdata : regs[raddr_a];
            rdata_b = (we && waddr == raddr_b) ? wdata : regs[raddr_b];
         end
      end else begin : g_nofwd
         always_comb begin
            rdata_a = regs[raddr_a];
            rdata_b = regs[raddr_b];
         end
      end
   endgenerate

   // R7: a write lands in the addressed register by the next cycle
   p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> regs[$past(waddr)] == $past(wdata));

   // R7: an unwritten register keeps its value
   p_no_write_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(regs[0]) && $stable(regs[NUM_REGS-1]));

endmodule

// File: rtl/agu_disp_ext.sv
module agu_disp_ext
   import agu_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DSZ_W-1:0]  size,
   input  logic [31:0]       disp_in,
   output logic [ADDR_W-1:0] disp_out
);

   disp_size_e sz;
   assign sz = disp_size_e'(size);

   always_comb begin
      unique case (sz)
         DSZ_NONE: disp_out = '0;
         DSZ_BYTE: disp_out = {{(ADDR_W-8){disp_in[7]}}, disp_in[7:0]};
         DSZ_HALF: disp_out = {{(ADDR_W-16){disp_in[15]}}, disp_in[15:0]};
         default:  disp_out = ADDR_W'(signed'(disp_in));
      endcase
   end

   // R5: an absent displacement contributes nothing
   p_none_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      size == DSZ_NONE |-> disp_out == '0);

   // R5: a byte displacement is a pure sign copy above bit 7
   p_byte_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
      size == DSZ_BYTE |->
         ($countones(disp_out[ADDR_W-1:7]) == 0 ||
          $countones(disp_out[ADDR_W-1:7]) == ADDR_W-7));

   // R5: a halfword displacement is a pure sign copy above bit 15
   p_half_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
      size == DSZ_HALF |->
         ($countones(disp_out[ADDR_W-1:15]) == 0 ||
          $countones(disp_out[ADDR_W-1:15]) == ADDR_W-15));

endmodule

// File: rtl/agu_index_scaler.sv
module agu_index_scaler
   import agu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int STYLE  = SCALE_SHIFTER
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               use_idx,
   input  logic [SCALE_W-1:0] scale,
   input  logic [ADDR_W-1:0]  idx_val,
   output logic [ADDR_W-1:0]  scaled
);

   logic [ADDR_W-1:0] shifted;

   generate
      if (STYLE == SCALE_SHIFTER) begin : g_shift
         assign shifted = idx_val << scale;
      end else begin : g_mux
         logic [ADDR_W-1:0] cand [2**SCALE_W];
         for (genvar s = 0; s < 2**SCALE_W; s++) begin : g_cand
            assign cand[s] = {idx_val[ADDR_W-1-s:0], {s{1'b0}}};
         end
         assign shifted = cand[scale];
      end
   endgenerate

   assign scaled = use_idx ? shifted : '0;

   // R3/R6: a suppressed index contributes nothing
   p_gated_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !use_idx |-> scaled == '0);

   // R4: scale by 8 leaves the three low bits clear
   p_x8_low_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      scale == 2'd3 |-> scaled[2:0] == 3'b000);

   // R4: unit scale passes the index through
   p_x1_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      use_idx && scale == 2'd0 |-> scaled == idx_val);

endmodule

// File: rtl/agu_sum3.sv
module agu_sum3
   import agu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int STYLE  = SUM_CSA
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   input  logic [ADDR_W-1:0] c,
   output logic [ADDR_W-1:0] sum
);

   generate
      if (STYLE == SUM_CSA) begin : g_csa
         logic [ADDR_W-1:0] psum;
         logic [ADDR_W-1:0] pcar;
         always_comb begin
            psum = a ^ b ^ c;
            pcar = ((a & b) | (a & c) | (b & c)) << 1;
         end
         assign sum = psum + pcar;
      end else begin : g_ripple
         assign sum = a + b + c;
      end
   endgenerate

endmodule

// File: rtl/agu_scaled_index.sv
module agu_scaled_index
   import agu_pkg::*;
#(
   parameter int NUM_REGS    = 8,
   parameter int ADDR_W      = 32,
   parameter int SP_REG      = 4,
   parameter bit RF_BYPASS   = 1'b1,
   parameter int SCALE_STYLE = SCALE_SHIFTER,
   parameter int SUM_STYLE   = SUM_CSA,
   localparam int SEL_W      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rf_we,
   input  logic [SEL_W-1:0]  rf_waddr,
   input  logic [ADDR_W-1:0] rf_wdata,
   input  logic              req_valid,
   input  logic              base_en,
   input  logic [SEL_W-1:0]  base_sel,
   input  logic              idx_en,
   input  logic [SEL_W-1:0]  idx_sel,
   input  logic [1:0]        scale_code,
   input  logic [1:0]        disp_size,
   input  logic [31:0]       disp,
   output logic              ea_valid,
   output logic [ADDR_W-1:0] ea_addr,
   output logic              ea_illegal
);

   generate
      if (ADDR_W < 32) begin : g_bad_width
         $error("agu_scaled_index: ADDR_W must be at least 32");
      end
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("agu_scaled_index: NUM_REGS must be a power of two >= 2");
      end
      if (SP_REG < 0 || SP_REG >= NUM_REGS) begin : g_bad_sp
         $error("agu_scaled_index: SP_REG out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] base_val, idx_val;
   logic [ADDR_W-1:0] base_term, idx_term, disp_term, sum_next;
   logic              idx_is_sp, use_idx, illegal_next;

   agu_regfile #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (ADDR_W),
      .BYPASS   (RF_BYPASS)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .raddr_a (base_sel),
      .raddr_b (idx_sel),
      .rdata_a (base_val),
      .rdata_b (idx_val)
   );

   assign idx_is_sp    = (idx_sel == SEL_W'(SP_REG));
   assign illegal_next = idx_en && idx_is_sp;
   assign use_idx      = idx_en && !idx_is_sp;
   assign base_term    = base_en ? base_val : '0;

   agu_index_scaler #(
      .ADDR_W (ADDR_W),
      .STYLE  (SCALE_STYLE)
   ) u_scale (
      .clk     (clk),
      .rst_n   (rst_n),
      .use_idx (use_idx),
      .scale   (scale_code),
      .idx_val (idx_val),
      .scaled  (idx_term)
   );

   agu_disp_ext #(
      .ADDR_W (ADDR_W)
   ) u_disp (
      .clk      (clk),
      .rst_n    (rst_n),
      .size     (disp_size),
      .disp_in  (disp),
      .disp_out (disp_term)
   );

   agu_sum3 #(
      .ADDR_W (ADDR_W),
      .STYLE  (SUM_STYLE)
   ) u_sum (
      .a   (base_term),
      .b   (idx_term),
      .c   (disp_term),
      .sum (sum_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_valid   <= 1'b0;
         ea_addr    <= '0;
         ea_illegal <= 1'b0;
      end else begin
         ea_valid <= req_valid;
         if (req_valid) begin
            ea_addr    <= sum_next;
            ea_illegal <= illegal_next;
         end
      end
   end

   // R2: a request produces a valid result one cycle later
   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ea_valid);

   // R2: no request, no valid
   p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !ea_valid);

   // R9: idle cycles keep the result
   p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(ea_addr) && $stable(ea_illegal));

   // R6: stack pointer as index is flagged
   p_sp_index_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && idx_en && idx_sel == SEL_W'(SP_REG) |=> ea_illegal);

   // R6: an absent index never raises the flag
   p_no_index_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !idx_en |=> !ea_illegal);

   // R3: base alone with no other term passes straight through
   p_base_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && base_en && !idx_en && disp_size == 2'd0 && !rf_we
         |=> ea_addr == $past(base_val));

endmodule

// File: tb/agu_scaled_index_bench.sv
`timescale 1ns/1ps
module agu_scaled_index_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rf_we = 1'b0;
   logic [2:0]  rf_waddr = '0;
   logic [31:0] rf_wdata = '0;
   logic        req_valid = 1'b0;
   logic        base_en = 1'b0;
   logic [2:0]  base_sel = '0;
   logic        idx_en = 1'b0;
   logic [2:0]  idx_sel = '0;
   logic [1:0]  scale_code = '0;
   logic [1:0]  disp_size = '0;
   logic [31:0] disp = '0;
   logic        ea_valid;
   logic [31:0] ea_addr;
   logic        ea_illegal;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   agu_scaled_index u_agu_scaled_index (
      .clk(clk), .rst_n(rst_n),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .req_valid(req_valid), .base_en(base_en), .base_sel(base_sel),
      .idx_en(idx_en), .idx_sel(idx_sel), .scale_code(scale_code),
      .disp_size(disp_size), .disp(disp),
      .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_illegal(ea_illegal)
   );

   typedef struct packed {
      logic        be;
      logic [2:0]  bs;
      logic        ie;
      logic [2:0]  is;
      logic [1:0]  sc;
      logic [1:0]  dz;
      logic [31:0] dv;
      logic [31:0] ex;
      logic        il;
   } vec_t;

   // registers: r0=1000 r1=100 r2=f000 r3=80000000 r4=deadbeef r5=10 r6=fffffff0 r7=12345678
   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 3'd2, 1'b0, 3'd0, 2'd0, 2'd1, 32'h0000_0008, 32'h0000_f008, 1'b0}, // R3 R5 base+disp8
      '{1'b1, 3'd2, 1'b1, 3'd1, 2'd0, 2'd0, 32'h0,         32'h0000_f100, 1'b0}, // R3 base+index
      '{1'b1, 3'd2, 1'b1, 3'd1, 2'd2, 2'd0, 32'h0,         32'h0000_f400, 1'b0}, // R4 x4
      '{1'b0, 3'd0, 1'b1, 3'd2, 2'd1, 2'd2, 32'h0000_0080, 32'h0001_e080, 1'b0}, // R4 no base x2
      '{1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0,         32'h0000_1000, 1'b0}, // R3 base only
      '{1'b1, 3'd0, 1'b1, 3'd5, 2'd3, 2'd0, 32'h0,         32'h0000_1080, 1'b0}, // R4 x8
      '{1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 2'd1, 32'haaaa_aaf0, 32'h0000_0ff0, 1'b0}, // R5 neg byte
      '{1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 2'd2, 32'h1234_8000, 32'hffff_9000, 1'b0}, // R5 neg half
      '{1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 2'd0, 32'hffff_ffff, 32'h0000_1000, 1'b0}, // R5 size 0
      '{1'b1, 3'd3, 1'b1, 3'd3, 2'd0, 2'd3, 32'h0000_0005, 32'h0000_0005, 1'b0}, // R8 wrap
      '{1'b1, 3'd6, 1'b0, 3'd0, 2'd0, 2'd1, 32'h0000_0020, 32'h0000_0010, 1'b0}, // R8 wrap byte
      '{1'b1, 3'd0, 1'b1, 3'd4, 2'd3, 2'd0, 32'h0,         32'h0000_1000, 1'b1}, // R6 sp index
      '{1'b1, 3'd0, 1'b0, 3'd4, 2'd3, 2'd0, 32'h0,         32'h0000_1000, 1'b0}, // R6 idx off
      '{1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 2'd3, 32'h1234_5678, 32'h1234_5678, 1'b0}, // R3 disp only
      '{1'b1, 3'd5, 1'b1, 3'd7, 2'd3, 2'd0, 32'h0,         32'h91a2_b3d0, 1'b0}, // R4 x8 overflow
      '{1'b0, 3'd0, 1'b1, 3'd6, 2'd1, 2'd1, 32'h0000_0040, 32'h0000_0020, 1'b0}  // R8 shifted wrap
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = a; rf_wdata = d;
      @(negedge clk);
      rf_we = 1'b0;
   endtask

   task automatic issue(input vec_t v);
      base_en = v.be; base_sel = v.bs; idx_en = v.ie; idx_sel = v.is;
      scale_code = v.sc; disp_size = v.dz; disp = v.dv; req_valid = 1'b1;
   endtask

   task automatic scramble();
      req_valid = 1'b0; base_en = 1'b1; base_sel = 3'd7; idx_en = 1'b1;
      idx_sel = 3'd4; scale_code = 2'd3; disp_size = 2'd3; disp = 32'h5555_aaaa;
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset valid", {31'd0, ea_valid}, 32'd0);
      chk("R1 reset addr", ea_addr, 32'd0);
      chk("R1 reset illegal", {31'd0, ea_illegal}, 32'd0);
      rst_n = 1'b1;

      wr_reg(3'd0, 32'h0000_1000);
      wr_reg(3'd1, 32'h0000_0100);
      wr_reg(3'd2, 32'h0000_f000);
      wr_reg(3'd3, 32'h8000_0000);
      wr_reg(3'd4, 32'hdead_beef);
      wr_reg(3'd5, 32'h0000_0010);
      wr_reg(3'd6, 32'hffff_fff0);
      wr_reg(3'd7, 32'h1234_5678);
      chk("R2 idle valid", {31'd0, ea_valid}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         issue(VECS[i]);
         @(negedge clk);
         chk($sformatf("R2 vec %0d valid", i), {31'd0, ea_valid}, 32'd1);
         chk($sformatf("R3 vec %0d addr", i), ea_addr, VECS[i].ex);
         chk($sformatf("R6 vec %0d illegal", i), {31'd0, ea_illegal}, {31'd0, VECS[i].il});
         scramble();
         @(negedge clk);
         chk($sformatf("R2 vec %0d drop", i), {31'd0, ea_valid}, 32'd0);
         chk($sformatf("R9 vec %0d hold addr", i), ea_addr, VECS[i].ex);
         chk($sformatf("R9 vec %0d hold illegal", i), {31'd0, ea_illegal}, {31'd0, VECS[i].il});
      end

      // R6: stack pointer is fine as a base
      @(negedge clk);
      issue('{1'b1, 3'd4, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0, 32'h0, 1'b0});
      @(negedge clk);
      chk("R6 sp as base addr", ea_addr, 32'hdead_beef);
      chk("R6 sp as base flag", {31'd0, ea_illegal}, 32'd0);
      scramble();

      // R7: write and read of the same register in one cycle
      @(negedge clk);
      rf_we = 1'b1; rf_waddr = 3'd5; rf_wdata = 32'h0000_0300;
      issue('{1'b1, 3'd5, 1'b1, 3'd5, 2'd1, 2'd0, 32'h0, 32'h0, 1'b0});
      @(negedge clk);
      rf_we = 1'b0;
      chk("R7 same-cycle forward", ea_addr, 32'h0000_0900);
      issue('{1'b1, 3'd5, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0, 32'h0, 1'b0});
      @(negedge clk);
      chk("R7 stored value", ea_addr, 32'h0000_0300);
      scramble();

      // R1: reset in mid run clears outputs and registers
      @(negedge clk);
      issue('{1'b1, 3'd7, 1'b0, 3'd0, 2'd0, 2'd0, 32'h0, 32'h0, 1'b0});
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid reset valid", {31'd0, ea_valid}, 32'd0);
      chk("R1 mid reset addr", ea_addr, 32'd0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first cycle after reset valid", {31'd0, ea_valid}, 32'd0);
      issue('{1'b1, 3'd2, 1'b1, 3'd7, 2'd3, 2'd0, 32'h0, 32'h0, 1'b0});
      @(negedge clk);
      chk("R1 registers cleared", ea_addr, 32'd0);
      scramble();
      @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule